// File: doc/BRIEF.md
# Single-Line Programmable-Trigger Interrupt Controller

This block watches one asynchronous interrupt wire, such as a power-management or watchdog alarm pin, and turns it into a clean, maskable interrupt request for a processor. The raw pin is first brought into the clock domain through a synchroniser. An event detector then reacts to a level or to an edge of either polarity, as chosen by a two-bit trigger field. A detected event latches a pending flag. The request to the processor is that flag gated by an enable bit.

Software reaches three 32-bit registers over a plain single-cycle read/write bus. The first holds the trigger type, the second the pending flag (a write of one acknowledges it), and the third the enable bit. Reads return every implemented bit, so drivers can update one field by read-modify-write. A build parameter places the three registers at either of two sets of byte offsets. The usual driver flow is to disable and acknowledge at start-up, program the trigger type, and then enable. On each interrupt the handler runs first and the acknowledge follows.

Top module: `single_line_irqc`

## Requirements
- R1: While reset is asserted and right after it, the trigger field reads 0, the enable bit reads 0, the pending bit reads 0 and `irq_out` is low.
- R2: The trigger register returns the trigger type in bits [1:0] and zero elsewhere. The pending and enable registers return their flag in bit 0 and zero elsewhere. A read at any unmapped offset returns 0. Only a write to the trigger register changes the trigger type.
- R3: With `LAYOUT_B` = 0 the trigger, pending and enable registers sit at byte offsets 0x00, 0x04 and 0x08. With `LAYOUT_B` = 1 they sit at 0x0C, 0x10 and 0x40.
- R4: `irq_out` is high exactly when the pending flag and the enable bit are both 1. Clearing the enable bit leaves the pending flag unchanged.
- R5: Trigger type 3 (rising edge) sets pending on a low-to-high change of `irq_in`. The change becomes visible on the third rising clock edge after the input changes.
- R6: Trigger type 1 (falling edge) sets pending on a high-to-low change of `irq_in`, and ignores rising changes.
- R7: Trigger type 2 (active-high level) and type 0 (active-low level) set pending while the synchronised input is at its active level. An acknowledge while the input is still active clears pending for one cycle, and pending is set again on the next clock edge.
- R8: Writing 1 to bit 0 of the pending register clears pending. Writing 0 has no effect. In edge modes, pending stays set after the input returns to its idle level, until it is acknowledged.
- R9: In edge modes, when a new edge is detected in the same cycle as an acknowledge, pending stays set.
- R10: A write to the trigger register masks edge detection in that cycle, so an edge seen in that cycle does not set pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 1 | Raw asynchronous interrupt line |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Gated interrupt request to the processor |

## Verification
The assertions assume that a bus access is a single-cycle strobe and that `irq_in` only changes far from a clock edge. The bench drives every input on the falling clock edge, so every sampled value is well defined. The acknowledge-priority and edge-hold properties also rely on the trigger type being stable around an acknowledge. Apart from the two directed cases that deliberately land a register write on the edge-detect cycle, the stimulus changes the trigger type only while the input has been stable for several cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned DATA_W = 32;

    // bit 0 selects edge detection, bit 1 selects high/rising polarity
    typedef enum logic [1:0] {
        TRIG_LVL_LOW   = 2'd0,
        TRIG_EDGE_FALL = 2'd1,
        TRIG_LVL_HIGH  = 2'd2,
        TRIG_EDGE_RISE = 2'd3
    } trig_e;

    typedef struct packed {
        trig_e trig;
        logic  en;
        logic  pend;
    } core_st_t;

    function automatic logic trig_is_edge(trig_e t);
        return t[0];
    endfunction

    function automatic logic trig_is_high(trig_e t);
        return t[1];
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[TOP-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[TOP];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  lvl_i,
    input  trig_e trig_i,
    input  logic  mask_i,
    output logic  evt_o,
    output logic  edge_mode_o
);
    logic hist_d, hist_q;
    logic rise, fall, edge_hit, lvl_hit;

    always_comb begin
        hist_d   = lvl_i;
        rise     = lvl_i & ~hist_q;
        fall     = ~lvl_i & hist_q;
        edge_hit = (trig_is_high(trig_i) ? rise : fall) & ~mask_i;
        lvl_hit  = (lvl_i == trig_is_high(trig_i));
        evt_o    = trig_is_edge(trig_i) ? edge_hit : lvl_hit;
    end

    assign edge_mode_o = trig_is_edge(trig_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/irqc_regmap.sv
module irqc_regmap
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter bit          LAYOUT_B = 1'b0
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  core_st_t          st_i,
    output logic              ctrl_we_o,
    output logic              en_we_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] OFF_CTRL = LAYOUT_B ? ADDR_W'('h0C) : ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] OFF_PEND = LAYOUT_B ? ADDR_W'('h10) : ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] OFF_EN   = LAYOUT_B ? ADDR_W'('h40) : ADDR_W'('h08);

    logic hit_ctrl, hit_pend, hit_en;

    always_comb begin
        hit_ctrl  = (addr_i == OFF_CTRL);
        hit_pend  = (addr_i == OFF_PEND);
        hit_en    = (addr_i == OFF_EN);
        ctrl_we_o = sel_i & wr_i & hit_ctrl;
        en_we_o   = sel_i & wr_i & hit_en;
        ack_o     = sel_i & wr_i & hit_pend & wdata_i[0];
        rdata_o   = '0;
        if (hit_ctrl)      rdata_o[1:0] = st_i.trig;
        else if (hit_pend) rdata_o[0]   = st_i.pend;
        else if (hit_en)   rdata_o[0]   = st_i.en;
    end
endmodule

// File: rtl/single_line_irqc.sv
module single_line_irqc
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter bit          LAYOUT_B    = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);
    core_st_t st_d, st_q;
    logic     lvl_sync;
    logic     ctrl_we, en_we, ack;
    logic     evt, edge_mode;
    logic [1:0] trig_q_w;

    irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (lvl_sync)
    );

    irqc_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl_sync),
        .trig_i     (st_q.trig),
        .mask_i     (ctrl_we),
        .evt_o      (evt),
        .edge_mode_o(edge_mode)
    );

    irqc_regmap #(.ADDR_W(ADDR_W), .LAYOUT_B(LAYOUT_B)) u_regmap (
        .sel_i    (bus_sel),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .st_i     (st_q),
        .ctrl_we_o(ctrl_we),
        .en_we_o  (en_we),
        .ack_o    (ack),
        .rdata_o  (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_we) st_d.trig = trig_e'(bus_wdata[1:0]);
        if (en_we)   st_d.en   = bus_wdata[0];
        if (edge_mode) begin
            // a fresh edge outranks the acknowledge
            st_d.pend = evt | (st_q.pend & ~ack);
        end else begin
            // the acknowledge outranks a level still active
            st_d.pend = ack ? 1'b0 : (st_q.pend | evt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{trig: TRIG_LVL_LOW, en: 1'b0, pend: 1'b0};
        else        st_q <= st_d;
    end

    assign irq_out  = st_q.pend & st_q.en;
    assign trig_q_w = st_q.trig;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       edge_mode,
    input logic       evt,
    input logic       ack,
    input logic       ctrl_we,
    input logic       pend_q,
    input logic       en_q,
    input logic [1:0] trig_q,
    input logic       irq_o
);
    assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && evt) |=> pend_q);  // also covers R6

    assert_lvl_ack_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && ack) |=> !pend_q);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && !evt && !ctrl_we) |=> !pend_q);

    assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && pend_q && !ack) |=> pend_q);

    assert_ack_with_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && evt) |=> pend_q);

    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q) |-> !irq_o);

    assert_trig_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we) |=> $stable(trig_q));
endmodule

bind single_line_irqc irqc_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_mode(edge_mode),
    .evt      (evt),
    .ack      (ack),
    .ctrl_we  (ctrl_we),
    .pend_q   (st_q.pend),
    .en_q     (st_q.en),
    .trig_q   (trig_q_w),
    .irq_o    (irq_out)
);

// File: tb/single_line_irqc_tb_top.sv
module single_line_irqc_tb_top;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_in = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rdata_a, rdata_b;
    logic          irq_a, irq_b;

    int checks = 0;
    int failures = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;  // 250 MHz

    single_line_irqc #(.ADDR_W(AW), .LAYOUT_B(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_a), .irq_out(irq_a)
    );

    single_line_irqc #(.ADDR_W(AW), .LAYOUT_B(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_b), .irq_out(irq_b)
    );

    localparam logic [AW-1:0] A_CTRL = 8'h00, A_PEND = 8'h04, A_EN = 8'h08;
    localparam logic [AW-1:0] B_CTRL = 8'h0C, B_EN = 8'h40;

    // {mode[1:0], input before, input after, expected pending}
    localparam int NV = 13;
    localparam logic [4:0] VEC [NV] = '{
        {2'd3, 1'b0, 1'b1, 1'b1}, {2'd3, 1'b1, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0}, {2'd3, 1'b1, 1'b1, 1'b0},
        {2'd1, 1'b1, 1'b0, 1'b1}, {2'd1, 1'b0, 1'b1, 1'b0},
        {2'd1, 1'b1, 1'b1, 1'b0},
        {2'd2, 1'b0, 1'b1, 1'b1}, {2'd2, 1'b0, 1'b0, 1'b0},
        {2'd2, 1'b1, 1'b0, 1'b1},
        {2'd0, 1'b1, 1'b0, 1'b1}, {2'd0, 1'b1, 1'b1, 1'b0},
        {2'd0, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_a(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = rdata_a;
        bus_sel = 1'b0;
    endtask

    task automatic rd_b(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = rdata_b;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1 reset state
        idle(3);
        rd_a(A_CTRL, rv); check("R1 ctrl", rv, 0);
        rd_a(A_PEND, rv); check("R1 pend", rv, 0);
        rd_a(A_EN, rv);   check("R1 en", rv, 0);
        check("R1 irq_out", {31'b0, irq_a}, 0);
        @(negedge clk); rst_n = 1'b1;
        wr(A_EN, 0); wr(A_PEND, 1);

        // R2 readback and unmapped offsets
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_a(A_CTRL, rv); check("R2 ctrl mask", rv, 3);
        wr(A_EN, 32'hFFFF_FFFE);
        rd_a(A_EN, rv); check("R2 en bit0", rv, 0);
        rd_a(8'h0C, rv); check("R2 unmapped", rv, 0);

        // R3 alternate layout
        wr(B_CTRL, 2);
        rd_b(B_CTRL, rv); check("R3 layoutB ctrl", rv, 2);
        rd_a(B_CTRL, rv); check("R3 layoutA no reg at 0x0C", rv, 0);
        wr(B_EN, 1);
        rd_b(B_EN, rv); check("R3 layoutB en", rv, 1);
        rd_b(A_EN, rv); check("R3 layoutB no reg at 0x08", rv, 0);

        // table walk: R5 R6 R7 across all trigger types
        wr(A_EN, 1);
        for (int i = 0; i < NV; i++) begin
            irq_in = VEC[i][2];
            idle(5);
            wr(A_CTRL, {30'b0, VEC[i][4:3]});
            wr(A_PEND, 1);
            irq_in = VEC[i][1];
            idle(5);
            rd_a(A_PEND, rv);
            check($sformatf("R5/R6/R7 vec%0d pend", i), rv, {31'b0, VEC[i][0]});
            check($sformatf("R4 vec%0d irq", i), {31'b0, irq_a}, {31'b0, VEC[i][0]});
        end

        // R5 latency: third clock edge
        wr(A_CTRL, 3); irq_in = 1'b0; idle(5); wr(A_PEND, 1);
        @(negedge clk); irq_in = 1'b1;
        @(negedge clk); check("R5 edge1", {31'b0, irq_a}, 0);
        @(negedge clk); check("R5 edge2", {31'b0, irq_a}, 0);
        @(negedge clk); check("R5 edge3", {31'b0, irq_a}, 1);

        // R8 hold, write-0, write-1
        irq_in = 1'b0; idle(5);
        rd_a(A_PEND, rv); check("R8 hold after idle", rv, 1);
        wr(A_PEND, 0);
        rd_a(A_PEND, rv); check("R8 write0 no effect", rv, 1);
        wr(A_PEND, 1);
        rd_a(A_PEND, rv); check("R8 write1 clears", rv, 0);

        // R4 gating
        irq_in = 1'b1; idle(5);
        wr(A_EN, 0);
        check("R4 disabled irq", {31'b0, irq_a}, 0);
        rd_a(A_PEND, rv); check("R4 pend kept", rv, 1);
        wr(A_EN, 1);
        check("R4 reenabled irq", {31'b0, irq_a}, 1);
        wr(A_PEND, 1);

        // R6 falling edge
        wr(A_CTRL, 1); idle(5); wr(A_PEND, 1);
        irq_in = 1'b0; idle(5);
        rd_a(A_PEND, rv); check("R6 fall sets", rv, 1);
        wr(A_PEND, 1);
        irq_in = 1'b1; idle(5);
        rd_a(A_PEND, rv); check("R6 rise ignored", rv, 0);

        // R7 level ack re-set timing
        wr(A_CTRL, 2); idle(5);
        check("R7 level pend", {31'b0, irq_a}, 1);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_PEND; bus_wdata = 1;
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 0;
        check("R7 cleared one cycle", {31'b0, irq_a}, 0);
        @(negedge clk); check("R7 set again", {31'b0, irq_a}, 1);

        // R9 edge coinciding with ack
        wr(A_CTRL, 3); irq_in = 1'b0; idle(5); wr(A_PEND, 1);
        @(negedge clk); irq_in = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(A_PEND, 1);
        rd_a(A_PEND, rv); check("R9 edge beats ack", rv, 1);
        wr(A_PEND, 1);

        // R10 trigger write masks the edge
        irq_in = 1'b0; idle(5); wr(A_PEND, 1);
        @(negedge clk); irq_in = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(A_CTRL, 3);
        idle(5);
        rd_a(A_PEND, rv); check("R10 masked edge", rv, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule